// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block pulls a block of configuration data out of a three-wire serial EEPROM and places it in host-visible registers. It reads a fixed number of 16-bit words in address order. It adds them together and accepts the image only when the sum shows the stored check word agrees. On success it publishes a station address and a set of configuration words and raises a valid flag. On failure, or when the load is cut short, it clears the flag and raises a fallback flag, so that system firmware can supply the configuration some other way.

A load begins on its own once hardware reset is released. A presence bit is captured from a pin level while reset is held. If that bit is low, the reset-time load issues only two serial clocks and gives up. A load requested by software always runs to the end, and only the checksum decides the outcome, whatever the presence bit says.

Software can also drive the serial pins directly through a pin-control register, which lets a utility program the EEPROM. A write-enable bit guards host writes to the station-address words.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: The presence bit is captured from `det_pin` while `rst_n` is low. It is readable at bit 2 of register 0.
- R2: With the presence bit at 0, the load after reset produces exactly two rising edges on `mw_sk` and then stops. Afterwards busy (register 0 bit 0) is 0, valid (bit 1) is 0 and fallback (bit 3) is 1.
- R3: With the presence bit at 1, the load after reset reads all 16 words, which is 400 serial clocks. A good checksum sets valid to 1 and fallback to 0.
- R4: The station-address words (registers 2 to 4) and configuration words (registers 5 to 8) take loaded data only when the checksum passes. After a failed or aborted load they keep their prior contents, which are zero after reset.
- R5: Writing 1 to bit 0 of register 0 while idle starts a full 16-word load whatever the presence bit. Valid then reflects only the checksum.
- R6: Each word transfer keeps `mw_cs` high throughout. It sends 1, then 1, then 0, then a 6-bit word address, MSB first, with words read in address order 0 to 15. The 16 data bits are then sampled MSB first at the rising edges of `mw_sk`.
- R7: The checksum passes exactly when the 16-bit wrap-around sum of all 16 words, check word included, is 0xFFFF. A missing device, which reads as all zeros, fails.
- R8: Host writes to registers 2 to 4 take effect only while write-enable (register 0 bit 8) is 1. Otherwise they are ignored.
- R9: In register 1, bit 0 is chip select, bit 1 is clock, bit 2 is data out and bit 4 is direct-drive enable. When enabled and idle, these bits drive `mw_cs`, `mw_sk` and `mw_di`. Reading bit 3 returns `mw_do`.
- R10: Busy is 1 during any load. Writes to register 1 made while busy are ignored.
- R11: Each high and each low phase of `mw_sk` during a load lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset; its release triggers the automatic load |
| det_pin | input | 1 | Pin level sampled during reset as the EEPROM presence bit |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host register index |
| reg_wdata | input | WORD_W | Host write data |
| reg_rdata | output | WORD_W | Host read data for `reg_addr` |
| mw_cs | output | 1 | EEPROM chip select |
| mw_sk | output | 1 | EEPROM serial clock |
| mw_di | output | 1 | Serial data toward the EEPROM |
| mw_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest situation to reach is a failed load that follows a successful one, where the published registers must hold the earlier image rather than zeros or the partly read new data. The stimulus first loads a random image with a correct check word. It then alters both a data word and the check word in the EEPROM model and requests a software load, so any leak of shadow data becomes visible. The abort path needs its own reset with the presence pin low. The write-while-busy case is reached by issuing a pin-control write a few cycles into a requested load.

// File: rtl/eecl_pkg.sv
package eecl_pkg;
   // register indices
   localparam int REG_CTRL = 0;
   localparam int REG_PINS = 1;
   // control / status bit positions
   localparam int CTL_BUSY  = 0;
   localparam int CTL_REQ   = 0;
   localparam int CTL_VALID = 1;
   localparam int CTL_DET   = 2;
   localparam int CTL_FALLB = 3;
   localparam int CTL_WREN  = 8;
   // pin-control bit positions
   localparam int PIN_CS = 0;
   localparam int PIN_SK = 1;
   localparam int PIN_DI = 2;
   localparam int PIN_DO = 3;
   localparam int PIN_EN = 4;
   // serial read command prefix: start bit then opcode
   localparam logic [2:0] MW_READ_PREFIX = 3'b110;
endpackage

// File: rtl/cfg_sum_acc.sv
module cfg_sum_acc #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              add,
   input  logic [WORD_W-1:0] word,
   output logic              pass
);
   logic [WORD_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (clear)  sum_q <= '0;
      else if (add)    sum_q <= sum_q + word;
   end

   assign pass = &sum_q;
endmodule

// File: rtl/mw_word_xfer.sv
module mw_word_xfer import eecl_pkg::*; #(
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 6,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              short_run,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mw_do,
   output logic              cs,
   output logic              sk,
   output logic              di,
   output logic              done,
   output logic [WORD_W-1:0] rdata
);
   localparam int CMD_BITS = 3 + ADDR_W;
   localparam int TOT_BITS = CMD_BITS + WORD_W;
   localparam int CW       = $clog2(TOT_BITS + 1);

   logic                active, short_q, tick;
   logic [CMD_BITS-1:0] tx;
   logic [CW-1:0]       bitn, last;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   if (CLK_DIV == 1) begin : g_div_none
      assign tick = active;
   end else begin : g_div_cnt
      localparam int DW = $clog2(CLK_DIV);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt <= '0;
         else if (!active)                    cnt <= '0;
         else if (cnt == DW'(CLK_DIV - 1))    cnt <= '0;
         else                                 cnt <= cnt + 1'b1;
      end
      assign tick = active && (cnt == DW'(CLK_DIV - 1));
   end

   assign last = short_q ? CW'(1) : CW'(TOT_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; sk <= 1'b0; tx <= '0; bitn <= '0;
         rdata <= '0; short_q <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active  <= 1'b1;
            sk      <= 1'b0;
            tx      <= {MW_READ_PREFIX, addr};
            bitn    <= '0;
            rdata   <= '0;
            short_q <= short_run;
         end else if (tick) begin
            if (!sk) begin
               sk <= 1'b1;
               if (bitn >= CW'(CMD_BITS)) rdata <= {rdata[WORD_W-2:0], mw_do};
            end else begin
               sk <= 1'b0;
               tx <= tx << 1;
               if (bitn == last) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bitn <= bitn + 1'b1;
               end
            end
         end
      end
   end

   assign cs = active;
   assign di = active & tx[CMD_BITS-1];

   AST_SK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sk) |-> cs); // R6
   AST_CS_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cs && !sk); // R6
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader import eecl_pkg::*; #(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 6,
   parameter int NUM_WORDS = 16,
   parameter int SA_WORDS  = 3,
   parameter int CFG_WORDS = 4,
   parameter int CLK_DIV   = 2,
   parameter int REG_AW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              det_pin,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              mw_cs,
   output logic              mw_sk,
   output logic              mw_di,
   input  logic              mw_do
);
   localparam int IW       = $clog2(NUM_WORDS);
   localparam int SA_BASE  = 2;
   localparam int CFG_BASE = SA_BASE + SA_WORDS;

   if (NUM_WORDS < 2 || NUM_WORDS > (1 << ADDR_W)) begin : g_bad_words
      $error("NUM_WORDS out of range for ADDR_W");
   end
   if (SA_WORDS + CFG_WORDS > NUM_WORDS - 1) begin : g_bad_split
      $error("payload words exceed image minus check word");
   end
   if (WORD_W < 9) begin : g_bad_width
      $error("WORD_W too narrow for control bits");
   end
   if (CFG_BASE + CFG_WORDS > (1 << REG_AW)) begin : g_bad_regs
      $error("REG_AW too small for register bank");
   end

   logic              det_q, busy, pend, short_q, go, finish, valid, fallback, wren;
   logic              bb_cs, bb_sk, bb_di, bb_en;
   logic [IW-1:0]     widx;
   logic              x_cs, x_sk, x_di, x_done, ck_pass, ck_add, commit;
   logic [WORD_W-1:0] x_data;
   logic              sw_req, start, use_bb, ctl_wr, pin_wr;
   logic [WORD_W-1:0] sa_rd  [SA_WORDS];
   logic [WORD_W-1:0] cfg_rd [CFG_WORDS];

   // presence bit follows the pin for as long as reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) det_q <= det_pin;
   end

   assign ctl_wr = reg_wr && (reg_addr == REG_AW'(REG_CTRL));
   assign pin_wr = reg_wr && (reg_addr == REG_AW'(REG_PINS));
   assign sw_req = ctl_wr && reg_wdata[CTL_REQ];
   assign start  = !busy && (pend || sw_req);
   assign ck_add = busy && x_done && !short_q;
   assign commit = finish && ck_pass;

   mw_word_xfer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_xfer (
      .clk(clk), .rst_n(rst_n), .start(go), .short_run(short_q),
      .addr(ADDR_W'(widx)), .mw_do(mw_do), .cs(x_cs), .sk(x_sk), .di(x_di),
      .done(x_done), .rdata(x_data));

   cfg_sum_acc #(.WORD_W(WORD_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .clear(start), .add(ck_add),
      .word(x_data), .pass(ck_pass));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; pend <= 1'b1; short_q <= 1'b0; go <= 1'b0;
         finish <= 1'b0; valid <= 1'b0; fallback <= 1'b0; widx <= '0;
      end else begin
         go     <= 1'b0;
         finish <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            pend    <= 1'b0;
            short_q <= pend && !det_q;
            widx    <= '0;
            go      <= 1'b1;
            valid   <= 1'b0;
         end else if (busy && x_done) begin
            if (short_q) begin
               busy     <= 1'b0;
               fallback <= 1'b1;
            end else if (widx == IW'(NUM_WORDS - 1)) begin
               finish <= 1'b1;
            end else begin
               widx <= widx + 1'b1;
               go   <= 1'b1;
            end
         end else if (finish) begin
            busy     <= 1'b0;
            valid    <= ck_pass;
            fallback <= !ck_pass;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wren <= 1'b0; bb_cs <= 1'b0; bb_sk <= 1'b0; bb_di <= 1'b0; bb_en <= 1'b0;
      end else begin
         if (ctl_wr) wren <= reg_wdata[CTL_WREN];
         if (pin_wr && !busy) begin
            bb_cs <= reg_wdata[PIN_CS];
            bb_sk <= reg_wdata[PIN_SK];
            bb_di <= reg_wdata[PIN_DI];
            bb_en <= reg_wdata[PIN_EN];
         end
      end
   end

   assign use_bb = bb_en && !busy;
   assign mw_cs  = use_bb ? bb_cs : x_cs;
   assign mw_sk  = use_bb ? bb_sk : x_sk;
   assign mw_di  = use_bb ? bb_di : x_di;

   for (genvar gi = 0; gi < SA_WORDS; gi++) begin : g_sa
      logic [WORD_W-1:0] sh, q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             sh <= '0;
         else if (ck_add && widx == IW'(gi))     sh <= x_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (commit)  q <= sh;
         else if (wren && reg_wr && reg_addr == REG_AW'(SA_BASE + gi)) q <= reg_wdata;
      end
      assign sa_rd[gi] = q;
   end

   for (genvar gi = 0; gi < CFG_WORDS; gi++) begin : g_cfg
      logic [WORD_W-1:0] sh, q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    sh <= '0;
         else if (ck_add && widx == IW'(SA_WORDS + gi)) sh <= x_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (commit) q <= sh;
      end
      assign cfg_rd[gi] = q;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(REG_CTRL)) begin
         reg_rdata[CTL_BUSY]  = busy;
         reg_rdata[CTL_VALID] = valid;
         reg_rdata[CTL_DET]   = det_q;
         reg_rdata[CTL_FALLB] = fallback;
         reg_rdata[CTL_WREN]  = wren;
      end
      if (reg_addr == REG_AW'(REG_PINS)) begin
         reg_rdata[PIN_CS] = bb_cs;
         reg_rdata[PIN_SK] = bb_sk;
         reg_rdata[PIN_DI] = bb_di;
         reg_rdata[PIN_DO] = mw_do;
         reg_rdata[PIN_EN] = bb_en;
      end
      for (int i = 0; i < SA_WORDS; i++)
         if (reg_addr == REG_AW'(SA_BASE + i)) reg_rdata = sa_rd[i];
      for (int i = 0; i < CFG_WORDS; i++)
         if (reg_addr == REG_AW'(CFG_BASE + i)) reg_rdata = cfg_rd[i];
   end

   AST_VALID_NOT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !fallback); // R4
   AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(busy)); // R3
   AST_ABORT_FALLS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && x_done && short_q) |=> (fallback && !busy && !valid)); // R2
   AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({bb_cs, bb_sk, bb_di, bb_en})); // R10
   AST_SA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!wren && !commit) |=> $stable(sa_rd[0])); // R8
endmodule

// File: tb/test_eeprom_cfg_loader.sv
module test_eeprom_cfg_loader;
   localparam int PERIOD = 10;
   localparam int DIV    = 2;
   localparam int NW     = 16;
   localparam int SAW    = 3;
   localparam int CFGW   = 4;

   logic        clk = 1'b0, rst_n = 1'b0, det_pin = 1'b0, reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0, reg_rdata;
   logic        mw_cs, mw_sk, mw_di, mw_do;

   eeprom_cfg_loader #(.CLK_DIV(DIV)) i_eeprom_cfg_loader (
      .clk(clk), .rst_n(rst_n), .det_pin(det_pin), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

   always #(PERIOD/2) clk = ~clk;

   // EEPROM model
   logic [15:0] mem [64];
   logic [8:0]  cmd;
   logic [15:0] msh;
   logic        mdo = 1'b0, present = 1'b1, bb_mode = 1'b0, bb_do = 1'b0;
   int          mbit, nseen, sk_rises, seen [64];
   bit          cmd_bad;
   time         t_r1, t_f1;
   int          checks = 0, errors = 0;
   bit          finished = 0;
   logic [15:0] wren_b = '0;

   assign mw_do = bb_mode ? bb_do : mdo;

   always @(posedge mw_cs) begin
      mbit = 0; cmd = '0; mdo = 1'b0;
   end

   always @(posedge mw_sk) begin
      sk_rises++;
      if (sk_rises == 1) t_r1 = $time;
      if (mw_cs && !bb_mode) begin
         if (mbit < 9) begin
            cmd = {cmd[7:0], mw_di};
            if (mbit == 8) begin
               if (cmd[8:6] != 3'b110) cmd_bad = 1;
               if (nseen < 64) seen[nseen] = int'(cmd[5:0]);
               nseen++;
               msh = present ? mem[cmd[5:0]] : 16'h0;
               mdo = msh[15];
            end
         end else begin
            msh = {msh[14:0], 1'b0};
            mdo = msh[15];
         end
         mbit++;
      end
   end

   always @(negedge mw_sk) if (t_f1 == 0) t_f1 = $time;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_obs();
      sk_rises = 0; nseen = 0; cmd_bad = 0; t_r1 = 0; t_f1 = 0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(0, s);
         if (!s[0]) break;
      end
   endtask

   function automatic logic [15:0] fix_sum();
      logic [15:0] s = '0;
      for (int i = 0; i < NW-1; i++) s = s + mem[i];
      return 16'hFFFF - s;
   endfunction

   task automatic fill_good();
      for (int i = 0; i < NW-1; i++) mem[i] = 16'($urandom);
      mem[NW-1] = fix_sum();
   endtask

   task automatic do_reset(input logic det);
      clr_obs();
      rst_n = 1'b0; det_pin = det;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      wren_b = '0;
   endtask

   task automatic sw_load();
      clr_obs();
      wr(0, wren_b | 16'h0001);
   endtask

   task automatic chk_status(input string req, input logic v, input logic f);
      logic [15:0] s;
      rd(0, s);
      chk(s[1] == v, {req, " valid"}, s[1], v);
      chk(s[3] == f, {req, " fallback"}, s[3], f);
   endtask

   task automatic chk_regs(input string req, input logic [15:0] e [SAW+CFGW]);
      logic [15:0] d;
      for (int i = 0; i < SAW+CFGW; i++) begin
         rd(2+i, d);
         chk(d == e[i], req, d, e[i]);
      end
   endtask

   task automatic chk_order(input string req);
      bit ok = (nseen == NW) && !cmd_bad;
      for (int i = 0; i < NW; i++) if (seen[i] != i) ok = 0;
      chk(ok, req, nseen, NW);
   endtask

   logic [15:0] exp_r [SAW+CFGW];
   logic [15:0] zero_r [SAW+CFGW];
   logic [15:0] s;

   task automatic take_exp();
      for (int i = 0; i < SAW+CFGW; i++) exp_r[i] = mem[i];
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < SAW+CFGW; i++) zero_r[i] = '0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      fill_good();

      // reset with presence low: abort after two clocks
      do_reset(1'b0);
      rd(0, s);
      chk(s[0] == 1'b1, "R10 busy after reset", s[0], 1);
      chk(s[2] == 1'b0, "R1 presence low", s[2], 0);
      wait_idle();
      chk(sk_rises == 2, "R2 two clocks", sk_rises, 2);
      chk_status("R2", 1'b0, 1'b1);
      chk_regs("R4 defaults after abort", zero_r);

      // software load ignores presence bit
      sw_load();
      rd(0, s);
      chk(s[0] == 1'b1, "R10 busy during load", s[0], 1);
      wait_idle();
      chk(sk_rises == NW*25, "R5 full length", sk_rises, NW*25);
      chk_status("R5", 1'b1, 1'b0);
      take_exp();
      chk_regs("R5 loaded", exp_r);
      chk_order("R6 command and order");
      chk((t_f1 - t_r1) == DIV*PERIOD, "R11 half period", 32'(t_f1 - t_r1), DIV*PERIOD);

      // random images with reset-time load
      for (int n = 0; n < 3; n++) begin
         fill_good();
         do_reset(1'b1);
         rd(0, s);
         chk(s[2] == 1'b1, "R1 presence high", s[2], 1);
         wait_idle();
         chk(sk_rises == NW*25, "R3 full length", sk_rises, NW*25);
         chk_status("R3", 1'b1, 1'b0);
         take_exp();
         chk_regs("R3 loaded", exp_r);
         chk_order("R6 order");
      end

      // failing checksum after a good load keeps previous image
      mem[0] = mem[0] ^ 16'h00F0;
      mem[NW-1] = mem[NW-1] + 16'h0001;
      sw_load();
      wait_idle();
      chk_status("R7 bad sum", 1'b0, 1'b1);
      chk_regs("R4 kept after fail", exp_r);

      // no device attached: all zero data fails
      present = 1'b0;
      do_reset(1'b1);
      wait_idle();
      chk_status("R7 no device", 1'b0, 1'b1);
      chk_regs("R4 defaults after fail", zero_r);
      present = 1'b1;

      // directed sum boundary: wrap-around to 0xFFFF
      for (int i = 0; i < NW-1; i++) mem[i] = 16'hFFFF;
      mem[NW-1] = 16'h000E;
      sw_load();
      wait_idle();
      chk_status("R7 wrap sum", 1'b1, 1'b0);
      take_exp();
      chk_regs("R7 wrap loaded", exp_r);

      // station address write gating
      wr(0, 16'h0000);
      wr(2, 16'h1234);
      rd(2, s);
      chk(s == 16'hFFFF, "R8 write ignored", s, 16'hFFFF);
      wren_b = 16'h0100;
      wr(0, wren_b);
      rd(0, s);
      chk(s[8] == 1'b1, "R8 enable bit", s[8], 1);
      wr(2, 16'hBEEF);
      rd(2, s);
      chk(s == 16'hBEEF, "R8 write taken", s, 16'hBEEF);

      // direct pin drive
      bb_mode = 1'b1; bb_do = 1'b1;
      wr(1, 16'h0017);
      @(negedge clk);
      chk({mw_cs, mw_sk, mw_di} == 3'b111, "R9 pins high", {mw_cs, mw_sk, mw_di}, 3'b111);
      rd(1, s);
      chk(s[3] == 1'b1, "R9 data in high", s[3], 1);
      bb_do = 1'b0;
      rd(1, s);
      chk(s[3] == 1'b0, "R9 data in low", s[3], 0);
      wr(1, 16'h0010);
      @(negedge clk);
      chk({mw_cs, mw_sk, mw_di} == 3'b000, "R9 pins low", {mw_cs, mw_sk, mw_di}, 3'b000);
      wr(1, 16'h0000);
      bb_mode = 1'b0;

      // pin writes during a load are dropped
      fill_good();
      sw_load();
      repeat (5) @(negedge clk);
      wr(1, 16'h0017);
      wait_idle();
      rd(1, s);
      chk((s & 16'h0017) == 16'h0000, "R10 pin write ignored", s, 0);
      chk_status("R10 load intact", 1'b1, 1'b0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule